// File: doc/BRIEF.md
# Center-Aligned PWM Channel with One-Sided Dead Time

This block drives one PWM pin from a timebase that it does not own. A shared counter outside the block counts up from 1 to a bus period P and then back down to 2, so the counter repeats every 2·P − 2 ticks. The block looks at the counter value and its direction. It asserts its pin in a window that is symmetric about the counter peak, and the width of that window is set by a programmed duty in ticks. Optionally, the block shortens the pulse on one side only. With leading-edge dead time it holds back the rising side by a tick count. With trailing-edge dead time it cuts short the falling side by the same count.

Software-side values are presented on the configuration inputs and captured by a one-cycle load strobe. These values are the bus period, duty, dead time, edge choice and polarity. Captured values stay pending until the counter passes its minimum value of 1, which is the period boundary. Only then do they become the working set. Several channels can therefore share one counter and switch cleanly at the same point.

Top module: `cpwm_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pwm_out` is 0. Reset loads a working and pending set of period 2, duty 0, dead time 0, trailing edge and active-high polarity.
- R2: A high `cfg_load` in a cycle captures the configuration inputs as the pending set. The working set takes the pending set only in a cycle where `cnt` equals 1. If both happen in the same cycle, the working set receives the previously pending values and the new values wait for the following boundary.
- R3: With threshold T = max(P − floor(duty/2), 2), the raw pulse is active when duty ≠ 0 and T ≤ `cnt` ≤ P, in both count directions. Its width is W = 2·(P − T) + 1 ticks, and duty 0 never produces a pulse.
- R4: With `dt_lead` = 1 and dead time D, the output is active only on raw-active ticks whose index k satisfies k ≥ D. The index k counts from 0 at the first raw-active tick: k = `cnt` − T while `cnt_dn` = 0 and k = 2·P − T − `cnt` while `cnt_dn` = 1.
- R5: With `dt_lead` = 0, the output is active only on raw-active ticks with k + D < W, so deassertion comes D ticks early.
- R6: When D ≥ W, the output stays inactive for the whole period with either edge choice.
- R7: `pol_high` = 1 drives 1 for active and 0 for inactive. `pol_high` = 0 inverts both levels, and the value follows the working set.
- R8: `pwm_out` is a register and reflects the counter value sampled on the previous clock edge.
- R9: A new bus period is buffered like the other fields. A counter running at a changed period is judged against the old P until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt | input | CW | Shared up/down counter value |
| cnt_dn | input | 1 | 1 while the counter is moving downward |
| cfg_period | input | CW | Bus period P to capture |
| cfg_duty | input | CW+1 | Duty in ticks to capture |
| cfg_dead | input | CW+1 | Dead time in ticks to capture |
| dt_lead | input | 1 | 1 = leading-edge dead time, 0 = trailing-edge |
| pol_high | input | 1 | 1 = active-high output, 0 = active-low |
| cfg_load | input | 1 | Capture strobe for the configuration inputs |
| pwm_out | output | 1 | PWM pin |

## Verification
The capture strobe and the period boundary can land in the same cycle, and that collision is the case of interest. The bench raises `cfg_load` on the tick where the counter reads 1. It then expects the full following period to run on the earlier pending values, with the new values appearing only one period later. Reloads in the middle of a period are also provoked at several counter values, and the scoreboard requires the waveform to stay unchanged until the next boundary.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic {
    EDGE_TRAIL = 1'b0,
    EDGE_LEAD  = 1'b1
  } dt_edge_e;

  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } pol_e;

  localparam int unsigned BOUNDARY_VAL = 1;
  localparam int unsigned MIN_THRESH   = 2;

endpackage

// File: rtl/cpwm_cfg_buf.sv
module cpwm_cfg_buf
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          at_bnd,
  input  logic [CW-1:0] in_period,
  input  logic [CW:0]   in_duty,
  input  logic [CW:0]   in_dead,
  input  dt_edge_e      in_edge,
  input  pol_e          in_pol,
  output logic [CW-1:0] act_period,
  output logic [CW:0]   act_duty,
  output logic [CW:0]   act_dead,
  output dt_edge_e      act_edge,
  output pol_e          act_pol
);

  localparam logic [CW-1:0] RST_PERIOD = CW'(MIN_THRESH);

  logic [CW-1:0] pend_period;
  logic [CW:0]   pend_duty;
  logic [CW:0]   pend_dead;
  dt_edge_e      pend_edge;
  pol_e          pend_pol;

  // pending set: written by the load strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_period <= RST_PERIOD;
      pend_duty   <= '0;
      pend_dead   <= '0;
      pend_edge   <= EDGE_TRAIL;
      pend_pol    <= POL_HIGH;
    end else if (load) begin
      pend_period <= in_period;
      pend_duty   <= in_duty;
      pend_dead   <= in_dead;
      pend_edge   <= in_edge;
      pend_pol    <= in_pol;
    end
  end

  // working set: copied from the pending set at the counter minimum
  always_ff @(posedge clk) begin
    if (rst) begin
      act_period <= RST_PERIOD;
      act_duty   <= '0;
      act_dead   <= '0;
      act_edge   <= EDGE_TRAIL;
      act_pol    <= POL_HIGH;
    end else if (at_bnd) begin
      act_period <= pend_period;
      act_duty   <= pend_duty;
      act_dead   <= pend_dead;
      act_edge   <= pend_edge;
      act_pol    <= pend_pol;
    end
  end

endmodule

// File: rtl/cpwm_window.sv
module cpwm_window
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cnt,
  input  logic          cnt_dn,
  input  logic [CW-1:0] period,
  input  logic [CW:0]   duty,
  input  logic [CW:0]   dead,
  input  dt_edge_e      dt_edge,
  output logic          on
);

  localparam int XW = CW + 2;
  localparam logic [XW-1:0] THR_FLOOR = XW'(MIN_THRESH);

  logic [XW-1:0] p_x, half_x, thr_x, c_x, d_x, wid_x, k_x;
  logic          raw;

  always_comb begin
    p_x    = XW'(period);
    c_x    = XW'(cnt);
    d_x    = XW'(dead);
    half_x = XW'(duty >> 1);
    thr_x  = (p_x > half_x) ? (p_x - half_x) : '0;
    if (thr_x < THR_FLOOR) thr_x = THR_FLOOR;
    raw    = (duty != '0) && (c_x >= thr_x) && (c_x <= p_x);
    wid_x  = ((p_x - thr_x) << 1) + XW'(1);
    k_x    = cnt_dn ? ((p_x << 1) - thr_x - c_x) : (c_x - thr_x);
    if (dt_edge == EDGE_LEAD) on = raw && (k_x >= d_x);
    else                      on = raw && ((k_x + d_x) < wid_x);
  end

endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_dn,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW:0]   cfg_duty,
  input  logic [CW:0]   cfg_dead,
  input  logic          dt_lead,
  input  logic          pol_high,
  input  logic          cfg_load,
  output logic          pwm_out
);

  logic          at_bnd;
  logic [CW-1:0] act_period;
  logic [CW:0]   act_duty;
  logic [CW:0]   act_dead;
  dt_edge_e      act_edge;
  pol_e          act_pol;
  logic          win_on;

  assign at_bnd = (cnt == CW'(BOUNDARY_VAL));

  cpwm_cfg_buf #(.CW(CW)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .load      (cfg_load),
    .at_bnd    (at_bnd),
    .in_period (cfg_period),
    .in_duty   (cfg_duty),
    .in_dead   (cfg_dead),
    .in_edge   (dt_edge_e'(dt_lead)),
    .in_pol    (pol_e'(pol_high)),
    .act_period(act_period),
    .act_duty  (act_duty),
    .act_dead  (act_dead),
    .act_edge  (act_edge),
    .act_pol   (act_pol)
  );

  cpwm_window #(.CW(CW)) u_win (
    .cnt    (cnt),
    .cnt_dn (cnt_dn),
    .period (act_period),
    .duty   (act_duty),
    .dead   (act_dead),
    .dt_edge(act_edge),
    .on     (win_on)
  );

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= (act_pol == POL_HIGH) ? win_on : ~win_on;
  end

endmodule

// File: rtl/cpwm_chk.sv
module cpwm_chk
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cnt,
  input logic          at_bnd,
  input logic          pwm_out,
  input logic [CW-1:0] act_period,
  input logic [CW:0]   act_duty,
  input logic [CW:0]   act_dead,
  input pol_e          act_pol
);

  // R1: reset forces the pin low on the next edge
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !pwm_out);

  // R2: working set moves only at the counter minimum
  assert_hold_cfg_R2: assert property (@(posedge clk) disable iff (rst)
    !at_bnd |=> ($stable(act_duty) && $stable(act_period) && $stable(act_dead)));

  // R3: zero duty keeps the pin at its inactive level
  assert_zero_duty_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (act_duty == '0 && !at_bnd) |=> (pwm_out == (act_pol == POL_LOW)));

  // R3: the counter minimum is below the lowest threshold, so inactive there
  assert_boundary_idle_R3: assert property (@(posedge clk) disable iff (rst)
    at_bnd |=> (pwm_out == ($past(act_pol) == POL_LOW)));

  // R3/R7: nonzero duty without dead time is active at the counter peak
  assert_peak_active_R3: assert property (@(posedge clk) disable iff (rst)
    (act_duty != '0 && act_dead == '0 && cnt == act_period && !at_bnd)
    |=> (pwm_out == (act_pol == POL_HIGH)));

endmodule

bind cpwm_top cpwm_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt       (cnt),
  .at_bnd    (at_bnd),
  .pwm_out   (pwm_out),
  .act_period(act_period),
  .act_duty  (act_duty),
  .act_dead  (act_dead),
  .act_pol   (act_pol)
);

// File: tb/test_cpwm_top.sv
module test_cpwm_top;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cnt = '0;
  logic          cnt_dn = 1'b0;
  logic [CW-1:0] cfg_period = '0;
  logic [CW:0]   cfg_duty = '0;
  logic [CW:0]   cfg_dead = '0;
  logic          dt_lead = 1'b0;
  logic          pol_high = 1'b1;
  logic          cfg_load = 1'b0;
  logic          pwm_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string scen_tag = "R3";

  // bench model of working and pending sets (R1 reset values)
  int m_p = 2, m_d = 0, m_dt = 0, m_e = 0, m_pol = 1;
  int s_p = 2, s_d = 0, s_dt = 0, s_e = 0, s_pol = 1;

  bit    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  cpwm_top #(.CW(CW)) i_cpwm_top (
    .clk(clk), .rst(rst), .cnt(cnt), .cnt_dn(cnt_dn),
    .cfg_period(cfg_period), .cfg_duty(cfg_duty), .cfg_dead(cfg_dead),
    .dt_lead(dt_lead), .pol_high(pol_high), .cfg_load(cfg_load),
    .pwm_out(pwm_out)
  );

  function automatic bit model_out(int c, bit dn, int p, int d, int dt, int e, int pol);
    int half, thr, w, k;
    bit raw, on;
    half = d / 2;
    thr  = (p > half) ? p - half : 0;
    if (thr < 2) thr = 2;
    raw  = (d != 0) && (c >= thr) && (c <= p);
    w    = 2 * (p - thr) + 1;
    k    = dn ? (2 * p - thr - c) : (c - thr);
    on   = raw && (e != 0 ? (k >= dt) : (k + dt < w));
    return pol != 0 ? on : !on;
  endfunction

  task automatic step(input int c, input bit dn, input bit rl);
    @(negedge clk);
    cnt = CW'(c);
    cnt_dn = dn;
    cfg_load = rl;
    exp_q.push_back(model_out(c, dn, m_p, m_d, m_dt, m_e, m_pol));
    tag_q.push_back($sformatf("R8/%s", scen_tag));
    if (c == 1) begin
      m_p = s_p; m_d = s_d; m_dt = s_dt; m_e = s_e; m_pol = s_pol;
    end
    if (rl) begin
      s_p = int'(cfg_period); s_d = int'(cfg_duty); s_dt = int'(cfg_dead);
      s_e = int'(dt_lead); s_pol = int'(pol_high);
    end
  endtask

  // one counter period at bus period P; reload pulse on tick index rl_at
  task automatic run(input int P, input int n, input int rl_at);
    for (int r = 0; r < n; r++) begin
      int idx = 0;
      for (int c = 1; c <= P; c++) begin
        step(c, 1'b0, (r == 0) && (idx == rl_at));
        idx++;
      end
      for (int c = P - 1; c >= 2; c--) begin
        step(c, 1'b1, (r == 0) && (idx == rl_at));
        idx++;
      end
    end
  endtask

  task automatic set_cfg(input int p, input int d, input int dt, input bit lead, input bit ph);
    cfg_period = CW'(p);
    cfg_duty   = (CW+1)'(d);
    cfg_dead   = (CW+1)'(dt);
    dt_lead    = lead;
    pol_high   = ph;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (pwm_out !== e) begin
          failures++;
          $display("FAIL %s cnt=%0d actual=%0b expected=%0b", t, cnt, pwm_out, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (pwm_out !== 1'b0) begin
      failures++;
      $display("FAIL R1 actual=%0b expected=0", pwm_out);
    end
    @(negedge clk);
    rst = 1'b0;

    // R2: load coincides with boundary -> old pending set runs a full period
    set_cfg(30, 20, 0, 1'b0, 1'b1);
    scen_tag = "R2"; run(30, 1, 0);
    scen_tag = "R3"; run(30, 2, -1);

    // R4: leading-edge dead time, loaded mid-period
    set_cfg(30, 20, 4, 1'b1, 1'b1);
    scen_tag = "R2"; run(30, 1, 40);
    scen_tag = "R4"; run(30, 2, -1);

    // R5: trailing-edge dead time
    set_cfg(30, 20, 4, 1'b0, 1'b1);
    scen_tag = "R2"; run(30, 1, 29);
    scen_tag = "R5"; run(30, 2, -1);

    // R6: dead time at and beyond pulse width (W = 21)
    set_cfg(30, 20, 21, 1'b1, 1'b1);
    scen_tag = "R6"; run(30, 2, 10);
    set_cfg(30, 20, 40, 1'b0, 1'b1);
    scen_tag = "R6"; run(30, 2, 10);

    // R7: active-low with leading dead time
    set_cfg(30, 12, 2, 1'b1, 1'b0);
    scen_tag = "R7"; run(30, 3, 3);

    // R3: odd duty of 1 and an oversize duty clamped at threshold 2
    set_cfg(30, 1, 0, 1'b0, 1'b1);
    scen_tag = "R3"; run(30, 2, 5);
    set_cfg(30, 70, 0, 1'b0, 1'b1);
    scen_tag = "R3"; run(30, 2, 5);

    // R9: bus period change to 20, buffered until the boundary
    set_cfg(20, 10, 1, 1'b0, 1'b1);
    scen_tag = "R9"; run(30, 1, 7);
    scen_tag = "R9"; run(20, 3, -1);

    // R3: zero duty stays idle
    set_cfg(20, 0, 0, 1'b0, 1'b1);
    scen_tag = "R3"; run(20, 3, 2);

    @(negedge clk);
    cfg_load = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end

endmodule